// File: doc/BRIEF.md
# Programmable Raster Timing Generator for TFT Panels

This block produces the complete raster timing for a TFT panel from a set of programmable geometry fields. It divides the system clock by a power of two to form the pixel rate, and two position counters walk each line and each frame through four regions. It drives horizontal and vertical sync, a data-enable line, the active-area pixel coordinates, and start-of-frame and start-of-line pulses. A downstream pixel fetch unit uses those outputs to pace its reads. Blanking pixels and blanking lines are generated here and never consume pixel data.

A small sequencer handles panel power. When the block is enabled it starts driving the raster at once, but it raises the panel supply enable only after a programmed number of whole frames. When the block is disabled, the supply enable drops first, and the raster keeps running for the same number of frames before it stops. Configuration is copied into a shadow set only at frame boundaries, and also continuously while the block is idle.

The raster cannot be stalled, so no output carries back-pressure. A consumer must accept each pixel position in the clock cycle in which `pix_ce` is high.

Top module: `lcd_raster_gen`

## Requirements
- R1: Every geometry field holds its length minus one, so a field value of 0 means one unit. A line is made of hsync (`cfg_hsync_w`+1 pixels), then back porch (`cfg_hback`+1), then active (`cfg_hactive`+1), then front porch (`cfg_hfront`+1). `hsync_o` is asserted only during the first region, and the line then repeats.
- R2: A frame orders its lines the same way: vsync (`cfg_vsync_w`+1 lines), back porch (`cfg_vback`+1), active (`cfg_vactive`+1), front porch (`cfg_vfront`+1). `vsync_o` is asserted only during the sync lines.
- R3: Data enable is asserted only when both positions are in their active regions. There, `pix_x`/`pix_y` give the zero-based offset into the active area; elsewhere both are 0.
- R4: A polarity bit of 1 inverts its line: `cfg_hs_inv`, `cfg_vs_inv` and `cfg_de_inv` make the sync or enable output active low, and `cfg_pclk_inv` inverts `pclk_o`. With all bits 0 every line is active high.
- R5: With prescale n, `pix_ce` is high one clock in every 2^n clocks while running. For n≥1, `pclk_o` (before inversion) is high in the second half of each pixel period, including the `pix_ce` cycle, and low in the first half. For n=0 it stays at its inactive level.
- R6: When enabled from idle, the raster starts at once. `panel_pwr` rises after `cfg_guard` completed frames, or in the next clock if the guard is 0.
- R7: When `enable` drops, `panel_pwr` falls in the next clock. The raster then runs for `cfg_guard` more completed frames, or stops at once if the guard is 0, and returns to idle.
- R8: A configuration change made mid-frame takes effect only at the next frame start. The current frame keeps its old length and polarities.
- R9: `sof_o` is high in the `pix_ce` cycle of the first pixel of a frame. `sol_o` is high in the `pix_ce` cycle of the first pixel of every line.
- R10: While idle (after reset or after power-down), `pix_ce`, `sof_o`, `sol_o` and `panel_pwr` are 0, the sync and enable lines sit at their inactive levels, and the coordinates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Request raster output and panel power |
| cfg_hsync_w | input | 6 | Hsync width minus one, in pixels |
| cfg_hback | input | 8 | Horizontal back porch minus one |
| cfg_hactive | input | 11 | Active pixels per line minus one |
| cfg_hfront | input | 11 | Horizontal front porch minus one |
| cfg_vsync_w | input | 6 | Vsync width minus one, in lines |
| cfg_vback | input | 8 | Vertical back porch minus one |
| cfg_vactive | input | 11 | Active lines minus one |
| cfg_vfront | input | 8 | Vertical front porch minus one |
| cfg_pclk_inv | input | 1 | Invert pixel clock output |
| cfg_de_inv | input | 1 | Data enable active low |
| cfg_vs_inv | input | 1 | Vsync active low |
| cfg_hs_inv | input | 1 | Hsync active low |
| cfg_prescale | input | 3 | Pixel clock divide exponent n |
| cfg_guard | input | 4 | Power guard time in frames |
| pix_ce | output | 1 | Pixel clock enable, one per pixel |
| pclk_o | output | 1 | Pixel clock level to the panel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_x | output | 11 | Active-area column |
| pix_y | output | 11 | Active-area row |
| sof_o | output | 1 | Start-of-frame pulse |
| sol_o | output | 1 | Start-of-line pulse |
| panel_pwr | output | 1 | Panel supply enable |

## Verification
A horizontal counter that goes wrong moves `hsync_o`, `de_o` and `pix_x` within the same line, and shifts every later `sol_o` pulse. A vertical counter fault appears at the next line boundary. A prescaler fault changes the gap between `pix_ce` pulses on the very next pixel. A shadow-load or sequencer fault is slower to surface: it shows as a frame of the wrong length, or as `panel_pwr` rising or falling one or more whole frames early or late. The bench compares every pixel against a reference raster, so each of these faults is reported at the first pixel it corrupts.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  localparam int SYNC_W  = 6;   // sync pulse up to 64
  localparam int HBP_W   = 8;   // horizontal back porch up to 256
  localparam int HFP_W   = 11;  // horizontal front porch up to 2048
  localparam int VP_W    = 8;   // vertical porches up to 256
  localparam int ACT_W   = 11;  // active size up to 2048
  localparam int PRE_W   = 3;   // divide exponent 0..7
  localparam int GUARD_W = 4;   // guard frames 0..15
  // widest line: 64 + 256 + 2048 + 2048 = 4416 positions
  localparam int CNT_W   = 13;

  typedef enum logic [1:0] {PS_OFF, PS_PRE, PS_ON, PS_POST} pwr_state_e;

  typedef struct packed {
    logic [SYNC_W-1:0]  hsw;
    logic [HBP_W-1:0]   hbp;
    logic [ACT_W-1:0]   hact;
    logic [HFP_W-1:0]   hfp;
    logic [SYNC_W-1:0]  vsw;
    logic [VP_W-1:0]    vbp;
    logic [ACT_W-1:0]   vact;
    logic [VP_W-1:0]    vfp;
    logic               pclk_inv;
    logic               de_inv;
    logic               vs_inv;
    logic               hs_inv;
    logic [PRE_W-1:0]   presc;
    logic [GUARD_W-1:0] guard;
  } raster_cfg_t;
endpackage

// File: rtl/lcd_pclk_div.sv
module lcd_pclk_div #(
  parameter int PW = 3,
  localparam int DIV_W = (1 << PW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] presc,
  output logic          pix_ce,
  output logic          phase
);
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] mask;
  logic [DIV_W-1:0] shifted;

  assign mask    = ~({DIV_W{1'b1}} << presc);
  assign pix_ce  = run && (div_cnt == mask);
  assign shifted = div_cnt >> (presc - 1'b1);
  assign phase   = (presc != '0) && shifted[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_cnt <= '0;
    else if (!run)       div_cnt <= '0;
    else if (pix_ce)     div_cnt <= '0;
    else                 div_cnt <= div_cnt + 1'b1;
  end

  // R5: with a divide above one, two pixel enables never sit back to back
  p_ce_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce && presc != '0) |=> (!pix_ce || presc == '0));
endmodule

// File: rtl/lcd_axis_cnt.sv
module lcd_axis_cnt #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] len_sync,
  input  logic [W-1:0] len_bp,
  input  logic [W-1:0] len_act,
  input  logic [W-1:0] len_fp,
  output logic [W-1:0] pos,
  output logic         last,
  output logic         in_sync,
  output logic         in_act,
  output logic [W-1:0] act_idx
);
  logic [W-1:0] b_act, b_fp, total;

  assign b_act   = len_sync + len_bp;
  assign b_fp    = b_act + len_act;
  assign total   = b_fp + len_fp;
  assign in_sync = pos < len_sync;
  assign in_act  = (pos >= b_act) && (pos < b_fp);
  assign last    = pos == (total - 1'b1);
  assign act_idx = pos - b_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= '0;
    else if (clr)    pos <= '0;
    else if (step)   pos <= last ? '0 : pos + 1'b1;
  end

  // R1: the position never leaves the programmed period
  p_pos_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pos < total);
  // R2: a step at the last position wraps to the sync region
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> pos == '0);
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq import lcd_raster_pkg::*; #(
  parameter int GW = GUARD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          frame_end,
  input  logic [GW-1:0] guard,
  output logic          run,
  output logic          pwr
);
  pwr_state_e    st;
  logic [GW-1:0] gcnt;
  logic          guard_done;

  assign guard_done = frame_end && (gcnt == guard - 1'b1);
  assign run        = st != PS_OFF;
  assign pwr        = st == PS_ON;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= PS_OFF;
      gcnt <= '0;
    end else begin
      case (st)
        PS_OFF: begin
          gcnt <= '0;
          if (enable) st <= (guard == '0) ? PS_ON : PS_PRE;
        end
        PS_PRE: begin
          if (!enable) begin
            gcnt <= '0;
            st   <= (guard == '0) ? PS_OFF : PS_POST;
          end else if (frame_end) begin
            gcnt <= gcnt + 1'b1;
            if (guard_done) st <= PS_ON;
          end
        end
        PS_ON: begin
          gcnt <= '0;
          if (!enable) st <= (guard == '0) ? PS_OFF : PS_POST;
        end
        default: begin
          if (frame_end) begin
            gcnt <= gcnt + 1'b1;
            if (guard_done) st <= PS_OFF;
          end
        end
      endcase
    end
  end

  // R6: power rises only on request and, with a guard, only at a frame end
  p_pwr_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr) |-> $past(enable));
  p_pwr_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr) && $past(guard) != '0) |-> $past(frame_end));
  // R7: power falls only after the request is withdrawn
  p_pwr_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr) |-> !$past(enable));
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen import lcd_raster_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [SYNC_W-1:0]  cfg_hsync_w,
  input  logic [HBP_W-1:0]   cfg_hback,
  input  logic [ACT_W-1:0]   cfg_hactive,
  input  logic [HFP_W-1:0]   cfg_hfront,
  input  logic [SYNC_W-1:0]  cfg_vsync_w,
  input  logic [VP_W-1:0]    cfg_vback,
  input  logic [ACT_W-1:0]   cfg_vactive,
  input  logic [VP_W-1:0]    cfg_vfront,
  input  logic               cfg_pclk_inv,
  input  logic               cfg_de_inv,
  input  logic               cfg_vs_inv,
  input  logic               cfg_hs_inv,
  input  logic [PRE_W-1:0]   cfg_prescale,
  input  logic [GUARD_W-1:0] cfg_guard,
  output logic               pix_ce,
  output logic               pclk_o,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic [ACT_W-1:0]   pix_x,
  output logic [ACT_W-1:0]   pix_y,
  output logic               sof_o,
  output logic               sol_o,
  output logic               panel_pwr
);
  raster_cfg_t      cfg_live, shadow;
  logic             run, frame_end, phase;
  logic             h_last, v_last, h_sync, v_sync, h_act, v_act, de_raw;
  logic [CNT_W-1:0] h_pos, v_pos, h_idx, v_idx;

  assign cfg_live = '{hsw: cfg_hsync_w, hbp: cfg_hback, hact: cfg_hactive,
                      hfp: cfg_hfront, vsw: cfg_vsync_w, vbp: cfg_vback,
                      vact: cfg_vactive, vfp: cfg_vfront,
                      pclk_inv: cfg_pclk_inv, de_inv: cfg_de_inv,
                      vs_inv: cfg_vs_inv, hs_inv: cfg_hs_inv,
                      presc: cfg_prescale, guard: cfg_guard};

  assign frame_end = pix_ce && h_last && v_last;

  // configuration follows the inputs while idle, and is frozen within a frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  shadow <= '0;
    else if (!run || frame_end)  shadow <= cfg_live;
  end

  lcd_pwr_seq #(.GW(GUARD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .frame_end(frame_end),
    .guard(shadow.guard), .run(run), .pwr(panel_pwr));

  lcd_pclk_div #(.PW(PRE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .presc(shadow.presc),
    .pix_ce(pix_ce), .phase(phase));

  lcd_axis_cnt #(.W(CNT_W)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .clr(!run), .step(pix_ce),
    .len_sync(CNT_W'(shadow.hsw) + CNT_W'(1)),
    .len_bp(CNT_W'(shadow.hbp) + CNT_W'(1)),
    .len_act(CNT_W'(shadow.hact) + CNT_W'(1)),
    .len_fp(CNT_W'(shadow.hfp) + CNT_W'(1)),
    .pos(h_pos), .last(h_last), .in_sync(h_sync), .in_act(h_act),
    .act_idx(h_idx));

  lcd_axis_cnt #(.W(CNT_W)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .clr(!run), .step(pix_ce && h_last),
    .len_sync(CNT_W'(shadow.vsw) + CNT_W'(1)),
    .len_bp(CNT_W'(shadow.vbp) + CNT_W'(1)),
    .len_act(CNT_W'(shadow.vact) + CNT_W'(1)),
    .len_fp(CNT_W'(shadow.vfp) + CNT_W'(1)),
    .pos(v_pos), .last(v_last), .in_sync(v_sync), .in_act(v_act),
    .act_idx(v_idx));

  assign de_raw  = run && h_act && v_act;
  assign hsync_o = shadow.hs_inv ^ (run && h_sync);
  assign vsync_o = shadow.vs_inv ^ (run && v_sync);
  assign de_o    = shadow.de_inv ^ de_raw;
  assign pclk_o  = shadow.pclk_inv ^ (run && phase);
  assign pix_x   = de_raw ? ACT_W'(h_idx) : '0;
  assign pix_y   = de_raw ? ACT_W'(v_idx) : '0;
  assign sol_o   = pix_ce && (h_pos == '0);
  assign sof_o   = sol_o && (v_pos == '0);

  // R3: data is never enabled inside a sync region
  p_de_outside_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw |-> (!h_sync && !v_sync));
  // R9: a frame start is always also a line start
  p_sof_is_sol_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> sol_o);
  // R10: an idle block issues no pixels and no power
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!pix_ce && !panel_pwr));
  // R8: inside a running frame the shadow set does not move
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(frame_end)) |-> $stable(shadow));
endmodule

// File: tb/lcd_raster_gen_bench.sv
module lcd_raster_gen_bench;
  import lcd_raster_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct {
    int hsw, hbp, hact, hfp, vsw, vbp, vact, vfp;
    bit pinv, dinv, vinv, hinv;
    int presc, guard;
  } tcfg_t;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [SYNC_W-1:0] hsw, vsw;
  logic [HBP_W-1:0] hbp;
  logic [ACT_W-1:0] hact, vact, px, py;
  logic [HFP_W-1:0] hfp;
  logic [VP_W-1:0] vbp, vfp;
  logic pinv, dinv, vinv, hinv;
  logic [PRE_W-1:0] presc;
  logic [GUARD_W-1:0] guard;
  logic pix_ce, pclk_o, hsync_o, vsync_o, de_o, sof_o, sol_o, panel_pwr;

  lcd_raster_gen u_lcd_raster_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_hsync_w(hsw), .cfg_hback(hbp), .cfg_hactive(hact), .cfg_hfront(hfp),
    .cfg_vsync_w(vsw), .cfg_vback(vbp), .cfg_vactive(vact), .cfg_vfront(vfp),
    .cfg_pclk_inv(pinv), .cfg_de_inv(dinv), .cfg_vs_inv(vinv), .cfg_hs_inv(hinv),
    .cfg_prescale(presc), .cfg_guard(guard),
    .pix_ce(pix_ce), .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .pix_x(px), .pix_y(py), .sof_o(sof_o), .sol_o(sol_o),
    .panel_pwr(panel_pwr));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [27:0] expq[$];
  int checks = 0, fails = 0, cyc = 0, last_ce = -1, gap = 1, e_presc = 0;
  bit mon_on = 0, e_pinv = 0, prev_ce = 0;
  tcfg_t ca, cb, cc;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_cfg(input tcfg_t c);
    hsw = SYNC_W'(c.hsw); hbp = HBP_W'(c.hbp); hact = ACT_W'(c.hact);
    hfp = HFP_W'(c.hfp); vsw = SYNC_W'(c.vsw); vbp = VP_W'(c.vbp);
    vact = ACT_W'(c.vact); vfp = VP_W'(c.vfp);
    pinv = c.pinv; dinv = c.dinv; vinv = c.vinv; hinv = c.hinv;
    presc = PRE_W'(c.presc); guard = GUARD_W'(c.guard);
  endtask

  // driver side of the scoreboard: reference raster built from R1, R2, R3, R9
  task automatic push_frame(input tcfg_t c, input int npix, input bit pwr_first,
                            input bit pwr_rest);
    int n = 0;
    int htot = c.hsw + c.hbp + c.hact + c.hfp + 4;
    int vtot = c.vsw + c.vbp + c.vact + c.vfp + 4;
    for (int v = 0; v < vtot; v++) begin
      for (int h = 0; h < htot; h++) begin
        bit hs_a, vs_a, ha, va, de;
        int x, y;
        logic [27:0] it;
        if (n >= npix) return;
        hs_a = h < c.hsw + 1;
        vs_a = v < c.vsw + 1;
        ha = (h >= c.hsw + c.hbp + 2) && (h < c.hsw + c.hbp + c.hact + 3);
        va = (v >= c.vsw + c.vbp + 2) && (v < c.vsw + c.vbp + c.vact + 3);
        de = ha && va;
        x = de ? h - (c.hsw + c.hbp + 2) : 0;
        y = de ? v - (c.vsw + c.vbp + 2) : 0;
        it = {(n == 0) ? pwr_first : pwr_rest, c.hinv ^ hs_a, c.vinv ^ vs_a,
              c.dinv ^ de, (h == 0 && v == 0), (h == 0), 11'(x), 11'(y)};
        expq.push_back(it);
        n++;
      end
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (prev_ce && e_presc != 0) chk("R5 pclk first half low", pclk_o, e_pinv);
      if (pix_ce) begin
        if (last_ce >= 0) chk("R5 pixel enable spacing", cyc - last_ce, gap);
        last_ce = cyc;
        chk("R4/R5 pclk level at pixel", pclk_o, e_pinv ^ (e_presc != 0));
        if (expq.size() == 0) chk("R1 unexpected pixel", 1, 0);
        else begin
          logic [27:0] it;
          it = expq.pop_front();
          chk("R6/R7 panel power", panel_pwr, it[27]);
          chk("R1/R4 hsync", hsync_o, it[26]);
          chk("R2/R4 vsync", vsync_o, it[25]);
          chk("R3/R4 data enable", de_o, it[24]);
          chk("R9 start of frame", sof_o, it[23]);
          chk("R9 start of line", sol_o, it[22]);
          chk("R3 pix_x", px, it[21:11]);
          chk("R3 pix_y", py, it[10:0]);
        end
      end
      prev_ce = pix_ce;
    end
  end

  task automatic wait_sof(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!sof_o);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int flen;
    ca = '{hsw:1, hbp:1, hact:3, hfp:2, vsw:0, vbp:0, vact:2, vfp:1,
           pinv:0, dinv:0, vinv:0, hinv:0, presc:0, guard:2};
    cb = '{hsw:0, hbp:2, hact:1, hfp:0, vsw:1, vbp:0, vact:1, vfp:0,
           pinv:0, dinv:1, vinv:1, hinv:1, presc:0, guard:2};
    cc = ca; cc.presc = 2; cc.guard = 0; cc.pinv = 1;
    drive_cfg(ca);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: idle after reset
    chk("R10 hsync idle", hsync_o, 0);
    chk("R10 vsync idle", vsync_o, 0);
    chk("R10 de idle", de_o, 0);
    chk("R10 pix_ce idle", pix_ce, 0);
    chk("R10 sof idle", sof_o, 0);
    chk("R10 power idle", panel_pwr, 0);

    // guard of two frames, divide by one, mid-frame reconfiguration
    e_pinv = 0; e_presc = 0; gap = 1; last_ce = -1; mon_on = 1;
    push_frame(ca, 77, 0, 0);
    push_frame(ca, 77, 0, 0);
    push_frame(ca, 77, 1, 1);
    push_frame(cb, 42, 1, 0);   // R7: power drops after first pixel
    push_frame(cb, 42, 0, 0);   // R7: one more guard frame with power off
    enable = 1'b1;
    wait_sof(3);
    flen = 0;
    do begin
      @(negedge clk);
      flen++;
      if (flen == 5) drive_cfg(cb);
    end while (!sof_o);
    chk("R8 frame kept old length", flen, 77);
    enable = 1'b0;
    repeat (120) @(negedge clk);
    chk("R7 raster stopped after guard", expq.size(), 0);
    chk("R7 pix_ce stopped", pix_ce, 0);
    chk("R10/R4 hsync idle inverted", hsync_o, 1);
    chk("R10/R4 vsync idle inverted", vsync_o, 1);
    chk("R10/R4 de idle inverted", de_o, 1);
    chk("R7 power off", panel_pwr, 0);

    // zero guard, divide by four, inverted pixel clock
    drive_cfg(cc);
    repeat (4) @(negedge clk);
    chk("R4 pclk idle inverted", pclk_o, 1);
    e_pinv = 1; e_presc = 2; gap = 4; last_ce = -1; prev_ce = 0;
    push_frame(cc, 77, 1, 1);
    push_frame(cc, 1, 1, 1);
    enable = 1'b1;
    @(negedge clk);
    chk("R6 zero guard powers at once", panel_pwr, 1);
    wait_sof(2);
    enable = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 zero guard stops at once", expq.size(), 0);
    chk("R7 power off", panel_pwr, 0);
    chk("R10 sol idle", sol_o, 0);
    chk("R10 pix_x idle", px, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule